// File: doc/BRIEF.md
# Virtualization-Aware Privilege Mode Controller

This block keeps track of the hart's current privilege level together with a virtualization bit that says whether a guest is running. It holds the saved-mode state that trap handlers and return instructions need. That state is the previous privilege and previous virtualization at the machine and hypervisor trap levels, the interrupt-enable stack bits for both levels, and the translation-level flags that record whether a fault came from the outer translation stage. A trap strobe carries a target level: machine, hypervisor-supervisor or guest supervisor. Three return strobes stand for the machine return, the supervisor return and the hypervisor return. A control bit lets software forbid supervisor-level returns from the hypervisor level.

All state is registered. An event presented in one cycle shows on the outputs after the next rising clock edge. The same edge raises an illegal flag for a return that is not allowed, or a swap strobe when the virtualization bit has changed. Choosing which level a trap goes to, steering the program counter and address translation all belong to neighbouring blocks.

Top module: `vpriv_ctrl`

## Requirements
- R1: After synchronous reset the hart is in machine mode (priv 2'b11) with virtualization 0. All saved-mode, enable-stack and translation-level bits are 0, and illegal_o and vswap_o are low.
- R2: A trap whose target is machine (trap_tgt_i 2'b00, or 2'b11, which is treated the same) copies the old virtualization bit into mpv_o, the old privilege into mpp_o and mie_o into mpie_o. It then clears mie_o and enters machine mode with virtualization 0.
- R3: A trap whose target is hypervisor-supervisor (2'b01) copies the old virtualization bit into spv_o and a 1 into spp_o when the old privilege was not user (0 otherwise). It also copies sie_o into spie_o, clears sie_o and enters privilege 2'b01 with virtualization 0.
- R4: A trap whose target is guest supervisor (2'b10) taken while virtualization is 1 writes spp_o and the sie_o/spie_o pair as in R3. It leaves spv_o, stl_o and the machine fields alone and enters privilege 2'b01 with virtualization 1. The same target while virtualization is 0 behaves as a hypervisor-supervisor trap.
- R5: A machine trap writes mtl_o and a hypervisor-supervisor trap writes stl_o. The bit is 0 when trap_xlat_flt_i is high (an access fault or an outer-stage page fault), and otherwise it is the old virtualization bit.
- R6: A machine return, legal only in machine mode, sets the privilege to mpp_o. It sets virtualization to mpv_o, or to 0 when mpp_o is 2'b11. It then clears mpp_o, copies mpie_o into mie_o and sets mpie_o.
- R7: A supervisor return is legal in machine mode, in guest supervisor mode, and in hypervisor-supervisor mode when tsr_i is 0. The privilege becomes spp_o. Virtualization becomes spv_o when it was 0 and stays 1 when it was 1. spp_o is cleared, sie_o takes spie_o and spie_o is set.
- R8: A hypervisor return is legal only in machine mode, or in hypervisor-supervisor mode with tsr_i 0. It sets spv_o to 1 and then acts as a supervisor return taken with virtualization 0.
- R9: A return strobe that is not legal in the current mode raises illegal_o for one cycle and leaves the mode and every saved field unchanged.
- R10: vswap_o is high for exactly the one cycle in which the new virtualization value is first visible, and only when that value differs from the previous one.
- R11: A trap strobe takes priority over any return strobe in the same cycle, and the returns it overrides raise no illegal flag. Among simultaneous returns, the machine return wins over the hypervisor return, which wins over the supervisor return.
- R12: The (virtualization, privilege) pair is always one of (0,U), (0,2'b01), (0,M), (1,U) or (1,2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_i | input | 1 | A trap is taken this cycle |
| trap_tgt_i | input | 2 | Trap target: 00 machine, 01 hypervisor-supervisor, 10 guest supervisor, 11 machine |
| trap_xlat_flt_i | input | 1 | Trap is an access fault or outer-stage page fault |
| mret_i | input | 1 | Machine return executes |
| sret_i | input | 1 | Supervisor return executes |
| hret_i | input | 1 | Hypervisor return executes |
| tsr_i | input | 1 | Forbid supervisor-level returns from hypervisor-supervisor mode |
| priv_o | output | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt_o | output | 1 | Current virtualization bit |
| illegal_o | output | 1 | Previous cycle's return was not allowed |
| vswap_o | output | 1 | Virtualization bit changed on the last edge |
| mpv_o | output | 1 | Saved virtualization at the machine level |
| mpp_o | output | 2 | Saved privilege at the machine level |
| mpie_o | output | 1 | Saved machine interrupt enable |
| mie_o | output | 1 | Machine interrupt enable |
| mtl_o | output | 1 | Machine-level translation-level flag |
| spv_o | output | 1 | Saved virtualization at the hypervisor level |
| spp_o | output | 1 | Saved privilege at the supervisor level |
| spie_o | output | 1 | Saved supervisor interrupt enable |
| sie_o | output | 1 | Supervisor interrupt enable |
| stl_o | output | 1 | Hypervisor-level translation-level flag |

## Verification
A trap and a return instruction can arrive in the same cycle, and so can several return strobes. The bench drives a trap together with a supervisor return from hypervisor mode. It also drives all three returns together from machine mode. The scoreboard expects the trap's result with no illegal flag in the first case, and only the machine return's effect in the second. Every other step is also judged at the edge after it, so the swap strobe and the illegal flag are checked for the exact cycle they belong to.

// File: rtl/vpriv_pkg.sv
package vpriv_pkg;

    typedef enum logic [1:0] {
        PRV_U   = 2'b00,
        PRV_S   = 2'b01,
        PRV_RSV = 2'b10,
        PRV_M   = 2'b11
    } prv_e;

    typedef enum logic [1:0] {
        TGT_M   = 2'b00,
        TGT_HS  = 2'b01,
        TGT_GS  = 2'b10,
        TGT_ALT = 2'b11
    } tgt_e;

    typedef struct packed {
        logic mpv;
        prv_e mpp;
        logic mpie;
        logic mie;
        logic mtl;
        logic spv;
        logic spp;
        logic spie;
        logic sie;
        logic stl;
    } stk_t;

    typedef struct packed {
        prv_e prv;
        logic virt;
        stk_t stk;
    } hart_t;

    localparam hart_t HART_RESET = '{prv: PRV_M, virt: 1'b0, stk: '0};

    // Collapse the alias code and fall back from guest to host level when no guest runs.
    function automatic tgt_e resolve_tgt(tgt_e t, logic virt);
        tgt_e r;
        r = t;
        if (t == TGT_ALT) r = TGT_M;
        else if (t == TGT_GS && !virt) r = TGT_HS;
        return r;
    endfunction

    // Supervisor-level return; force_spv models the hypervisor return's pre-step.
    function automatic hart_t sret_apply(hart_t h, logic force_spv);
        hart_t r;
        logic  pv;
        r          = h;
        pv         = force_spv ? 1'b1 : h.stk.spv;
        r.stk.spv  = pv;
        r.prv      = h.stk.spp ? PRV_S : PRV_U;
        r.virt     = h.virt ? 1'b1 : pv;
        r.stk.spp  = 1'b0;
        r.stk.sie  = h.stk.spie;
        r.stk.spie = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/vpriv_trap_unit.sv
module vpriv_trap_unit
    import vpriv_pkg::*;
(
    input  hart_t cur_i,
    input  tgt_e  tgt_i,
    input  logic  xlat_flt_i,
    output hart_t nxt_o
);

    tgt_e eff_tgt;
    logic tl_val;

    assign eff_tgt = resolve_tgt(tgt_i, cur_i.virt);
    assign tl_val  = xlat_flt_i ? 1'b0 : cur_i.virt;

    always_comb begin
        nxt_o = cur_i;
        case (eff_tgt)
            TGT_HS: begin
                nxt_o.stk.spv  = cur_i.virt;
                nxt_o.stk.spp  = (cur_i.prv != PRV_U);
                nxt_o.stk.spie = cur_i.stk.sie;
                nxt_o.stk.sie  = 1'b0;
                nxt_o.stk.stl  = tl_val;
                nxt_o.prv      = PRV_S;
                nxt_o.virt     = 1'b0;
            end
            TGT_GS: begin
                nxt_o.stk.spp  = (cur_i.prv != PRV_U);
                nxt_o.stk.spie = cur_i.stk.sie;
                nxt_o.stk.sie  = 1'b0;
                nxt_o.prv      = PRV_S;
                nxt_o.virt     = 1'b1;
            end
            default: begin
                nxt_o.stk.mpv  = cur_i.virt;
                nxt_o.stk.mpp  = cur_i.prv;
                nxt_o.stk.mpie = cur_i.stk.mie;
                nxt_o.stk.mie  = 1'b0;
                nxt_o.stk.mtl  = tl_val;
                nxt_o.prv      = PRV_M;
                nxt_o.virt     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vpriv_ret_unit.sv
module vpriv_ret_unit
    import vpriv_pkg::*;
(
    input  hart_t cur_i,
    input  logic  mret_i,
    input  logic  sret_i,
    input  logic  hret_i,
    input  logic  tsr_i,
    output hart_t nxt_o,
    output logic  take_o,
    output logic  illegal_o
);

    logic in_m, in_hs, in_vs;

    assign in_m  = (cur_i.prv == PRV_M);
    assign in_hs = !cur_i.virt && (cur_i.prv == PRV_S);
    assign in_vs = cur_i.virt && (cur_i.prv == PRV_S);

    always_comb begin
        nxt_o     = cur_i;
        take_o    = 1'b0;
        illegal_o = 1'b0;
        if (mret_i) begin
            if (in_m) begin
                take_o         = 1'b1;
                nxt_o.prv      = cur_i.stk.mpp;
                nxt_o.virt     = (cur_i.stk.mpp == PRV_M) ? 1'b0 : cur_i.stk.mpv;
                nxt_o.stk.mpp  = PRV_U;
                nxt_o.stk.mie  = cur_i.stk.mpie;
                nxt_o.stk.mpie = 1'b1;
            end else begin
                illegal_o = 1'b1;
            end
        end else if (hret_i) begin
            if (in_m || (in_hs && !tsr_i)) begin
                take_o = 1'b1;
                nxt_o  = sret_apply(cur_i, 1'b1);
            end else begin
                illegal_o = 1'b1;
            end
        end else if (sret_i) begin
            if (in_m || in_vs || (in_hs && !tsr_i)) begin
                take_o = 1'b1;
                nxt_o  = sret_apply(cur_i, 1'b0);
            end else begin
                illegal_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vpriv_ctrl.sv
module vpriv_ctrl
    import vpriv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trap_i,
    input  logic [1:0] trap_tgt_i,
    input  logic       trap_xlat_flt_i,
    input  logic       mret_i,
    input  logic       sret_i,
    input  logic       hret_i,
    input  logic       tsr_i,
    output logic [1:0] priv_o,
    output logic       virt_o,
    output logic       illegal_o,
    output logic       vswap_o,
    output logic       mpv_o,
    output logic [1:0] mpp_o,
    output logic       mpie_o,
    output logic       mie_o,
    output logic       mtl_o,
    output logic       spv_o,
    output logic       spp_o,
    output logic       spie_o,
    output logic       sie_o,
    output logic       stl_o
);

    hart_t cur_q, nxt, trap_nxt, ret_nxt;
    logic  ret_take, ret_bad;
    logic  ill_q, swap_q;

    vpriv_trap_unit u_trap (
        .cur_i      (cur_q),
        .tgt_i      (tgt_e'(trap_tgt_i)),
        .xlat_flt_i (trap_xlat_flt_i),
        .nxt_o      (trap_nxt)
    );

    vpriv_ret_unit u_ret (
        .cur_i     (cur_q),
        .mret_i    (mret_i),
        .sret_i    (sret_i),
        .hret_i    (hret_i),
        .tsr_i     (tsr_i),
        .nxt_o     (ret_nxt),
        .take_o    (ret_take),
        .illegal_o (ret_bad)
    );

    // A trap pre-empts whatever return was in flight.
    always_comb begin
        if (trap_i)        nxt = trap_nxt;
        else if (ret_take) nxt = ret_nxt;
        else               nxt = cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= HART_RESET;
            ill_q  <= 1'b0;
            swap_q <= 1'b0;
        end else begin
            cur_q  <= nxt;
            ill_q  <= !trap_i && ret_bad;
            swap_q <= (nxt.virt != cur_q.virt);
        end
    end

    assign priv_o    = cur_q.prv;
    assign virt_o    = cur_q.virt;
    assign illegal_o = ill_q;
    assign vswap_o   = swap_q;
    assign mpv_o     = cur_q.stk.mpv;
    assign mpp_o     = cur_q.stk.mpp;
    assign mpie_o    = cur_q.stk.mpie;
    assign mie_o     = cur_q.stk.mie;
    assign mtl_o     = cur_q.stk.mtl;
    assign spv_o     = cur_q.stk.spv;
    assign spp_o     = cur_q.stk.spp;
    assign spie_o    = cur_q.stk.spie;
    assign sie_o     = cur_q.stk.sie;
    assign stl_o     = cur_q.stk.stl;

endmodule

// File: rtl/vpriv_chk.sv
module vpriv_chk (
    input logic       clk,
    input logic       rst,
    input logic       trap_i,
    input logic [1:0] trap_tgt_i,
    input logic       mret_i,
    input logic       hret_i,
    input logic [1:0] priv_o,
    input logic       virt_o,
    input logic       illegal_o,
    input logic       vswap_o,
    input logic       mpv_o,
    input logic [1:0] mpp_o,
    input logic       mpie_o,
    input logic       mie_o,
    input logic       mtl_o,
    input logic       spv_o,
    input logic       spp_o,
    input logic       spie_o,
    input logic       sie_o,
    input logic       stl_o
);

    logic [13:0] snap;
    assign snap = {priv_o, virt_o, mpv_o, mpp_o, mpie_o, mie_o, mtl_o,
                   spv_o, spp_o, spie_o, sie_o, stl_o};

    // R12
    a_r12_legal_pair: assert property (@(posedge clk) disable iff (rst)
        (priv_o != 2'b10) && !(virt_o && priv_o == 2'b11));

    // R10
    a_r10_swap_on_change: assert property (@(posedge clk) disable iff (rst)
        (virt_o != $past(virt_o)) |-> vswap_o);

    a_r10_swap_only_on_change: assert property (@(posedge clk) disable iff (rst)
        vswap_o |-> (virt_o != $past(virt_o)));

    // R9
    a_r9_illegal_holds_state: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(snap));

    // R2
    a_r2_machine_trap: assert property (@(posedge clk) disable iff (rst)
        (trap_i && (trap_tgt_i == 2'b00 || trap_tgt_i == 2'b11))
        |=> (priv_o == 2'b11 && !virt_o && mpv_o == $past(virt_o) && mpp_o == $past(priv_o)));

    // R11
    a_r11_trap_no_illegal: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> !illegal_o);

    // R6
    a_r6_mret_stack: assert property (@(posedge clk) disable iff (rst)
        (mret_i && !trap_i && priv_o == 2'b11) |=> (mpp_o == 2'b00 && mpie_o));

    // R8
    a_r8_hret_enters_guest: assert property (@(posedge clk) disable iff (rst)
        (hret_i && !mret_i && !trap_i && priv_o == 2'b11) |=> (virt_o && spv_o));

endmodule

bind vpriv_ctrl vpriv_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .trap_i     (trap_i),
    .trap_tgt_i (trap_tgt_i),
    .mret_i     (mret_i),
    .hret_i     (hret_i),
    .priv_o     (priv_o),
    .virt_o     (virt_o),
    .illegal_o  (illegal_o),
    .vswap_o    (vswap_o),
    .mpv_o      (mpv_o),
    .mpp_o      (mpp_o),
    .mpie_o     (mpie_o),
    .mie_o      (mie_o),
    .mtl_o      (mtl_o),
    .spv_o      (spv_o),
    .spp_o      (spp_o),
    .spie_o     (spie_o),
    .sie_o      (sie_o),
    .stl_o      (stl_o)
);

// File: tb/vpriv_ctrl_bench.sv
`timescale 1ns/1ps
module vpriv_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trap_i = 1'b0;
    logic [1:0] trap_tgt_i = 2'b00;
    logic       trap_xlat_flt_i = 1'b0;
    logic       mret_i = 1'b0;
    logic       sret_i = 1'b0;
    logic       hret_i = 1'b0;
    logic       tsr_i = 1'b0;
    logic [1:0] priv_o, mpp_o;
    logic       virt_o, illegal_o, vswap_o, mpv_o, mpie_o, mie_o, mtl_o;
    logic       spv_o, spp_o, spie_o, sie_o, stl_o;

    always #2.5 clk = ~clk;

    vpriv_ctrl u_vpriv_ctrl (
        .clk(clk), .rst(rst), .trap_i(trap_i), .trap_tgt_i(trap_tgt_i),
        .trap_xlat_flt_i(trap_xlat_flt_i), .mret_i(mret_i), .sret_i(sret_i),
        .hret_i(hret_i), .tsr_i(tsr_i), .priv_o(priv_o), .virt_o(virt_o),
        .illegal_o(illegal_o), .vswap_o(vswap_o), .mpv_o(mpv_o), .mpp_o(mpp_o),
        .mpie_o(mpie_o), .mie_o(mie_o), .mtl_o(mtl_o), .spv_o(spv_o),
        .spp_o(spp_o), .spie_o(spie_o), .sie_o(sie_o), .stl_o(stl_o)
    );

    typedef struct {
        string       tag;
        logic [15:0] val;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // Reference state, derived from the requirements.
    logic [1:0] e_priv = 2'b11, e_mpp = 2'b00;
    logic e_v = 0, e_mpv = 0, e_mpie = 0, e_mie = 0, e_mtl = 0;
    logic e_spv = 0, e_spp = 0, e_spie = 0, e_sie = 0, e_stl = 0;

    task automatic do_sret_body();
        e_priv = e_spp ? 2'b01 : 2'b00;
        if (!e_v) e_v = e_spv;
        e_spp  = 1'b0;
        e_sie  = e_spie;
        e_spie = 1'b1;
    endtask

    task automatic step(input string tag, input logic tr, input logic [1:0] tg,
                        input logic fl, input logic mr, input logic sr,
                        input logic hr, input logic ts);
        logic old_v, ill;
        logic [1:0] t;
        item_t it;
        @(negedge clk);
        trap_i = tr; trap_tgt_i = tg; trap_xlat_flt_i = fl;
        mret_i = mr; sret_i = sr; hret_i = hr; tsr_i = ts;
        old_v = e_v;
        ill   = 1'b0;
        if (tr) begin
            t = tg;
            if (t == 2'b11) t = 2'b00;
            if (t == 2'b10 && !e_v) t = 2'b01;
            if (t == 2'b00) begin
                e_mpv = e_v; e_mpp = e_priv; e_mpie = e_mie; e_mie = 0;
                e_mtl = fl ? 1'b0 : e_v; e_priv = 2'b11; e_v = 0;
            end else if (t == 2'b01) begin
                e_spv = e_v; e_spp = (e_priv != 2'b00); e_spie = e_sie; e_sie = 0;
                e_stl = fl ? 1'b0 : e_v; e_priv = 2'b01; e_v = 0;
            end else begin
                e_spp = (e_priv != 2'b00); e_spie = e_sie; e_sie = 0;
                e_priv = 2'b01; e_v = 1;
            end
        end else if (mr) begin
            if (e_priv == 2'b11) begin
                e_v = (e_mpp == 2'b11) ? 1'b0 : e_mpv;
                e_priv = e_mpp; e_mpp = 2'b00; e_mie = e_mpie; e_mpie = 1;
            end else ill = 1;
        end else if (hr) begin
            if (e_priv == 2'b11 || (!e_v && e_priv == 2'b01 && !ts)) begin
                e_spv = 1; do_sret_body();
            end else ill = 1;
        end else if (sr) begin
            if (e_priv == 2'b11 || (e_priv == 2'b01 && (e_v || !ts))) do_sret_body();
            else ill = 1;
        end
        it.tag = tag;
        it.val = {e_priv, e_v, ill, (e_v != old_v), e_mpv, e_mpp, e_mpie, e_mie,
                  e_mtl, e_spv, e_spp, e_spie, e_sie, e_stl};
        q.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 2'b00, 0, 0, 0, 0, 0);
    endtask

    // Monitor: compare after each edge, away from it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = {priv_o, virt_o, illegal_o, vswap_o, mpv_o, mpp_o, mpie_o,
                       mie_o, mtl_o, spv_o, spp_o, spie_o, sie_o, stl_o};
                n_checks++;
                if (act !== it.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.val);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");
        step("R6 mret to user",               0, 2'b00, 0, 1, 0, 0, 0);
        step("R9 sret in user",               0, 2'b00, 0, 0, 1, 0, 0);
        step("R9 mret in user",               0, 2'b00, 0, 1, 0, 0, 0);
        step("R9 hret in user",               0, 2'b00, 0, 0, 0, 1, 0);
        step("R3 trap to host supervisor",    1, 2'b01, 0, 0, 0, 0, 0);
        step("R9 hret with tsr",              0, 2'b00, 0, 0, 0, 1, 1);
        step("R8 hret enters guest",          0, 2'b00, 0, 0, 0, 1, 0);
        idle("R10 swap lasts one cycle");
        step("R4 trap to guest supervisor",   1, 2'b10, 0, 0, 0, 0, 0);
        step("R7 sret inside guest",          0, 2'b00, 0, 0, 1, 0, 0);
        step("R2 trap to machine from guest", 1, 2'b00, 0, 0, 0, 0, 0);
        step("R6 mret back to guest",         0, 2'b00, 0, 1, 0, 0, 0);
        step("R5 fault clears stl",           1, 2'b01, 1, 0, 0, 0, 0);
        step("R3 trap host to host",          1, 2'b01, 0, 0, 0, 0, 0);
        step("R5 machine trap from host",     1, 2'b00, 0, 0, 0, 0, 0);
        step("R11 three returns at once",     0, 2'b00, 0, 1, 1, 1, 0);
        step("R11 trap beats sret",           1, 2'b00, 0, 0, 1, 0, 1);
        step("R2 trap machine to machine",    1, 2'b00, 0, 0, 0, 0, 0);
        step("R6 mret with mpp machine",      0, 2'b00, 0, 1, 0, 0, 0);
        step("R6 mret to user again",         0, 2'b00, 0, 1, 0, 0, 0);
        step("R4 guest target without guest", 1, 2'b10, 0, 0, 0, 0, 0);
        step("R7 sret host to user",          0, 2'b00, 0, 0, 1, 0, 0);
        step("R2 alias target code",          1, 2'b11, 0, 0, 0, 0, 0);
        step("R8 hret from machine",          0, 2'b00, 0, 0, 0, 1, 0);
        step("R4 guest trap again",           1, 2'b10, 0, 0, 0, 0, 0);
        step("R9 hret in guest",              0, 2'b00, 0, 0, 0, 1, 0);
        step("R9 mret in guest",              0, 2'b00, 0, 1, 0, 0, 0);
        step("R5 stl takes old virt",         1, 2'b01, 0, 0, 0, 0, 0);
        step("R9 sret host with tsr",         0, 2'b00, 0, 0, 1, 0, 1);
        step("R7 sret host into guest",       0, 2'b00, 0, 0, 1, 0, 0);
        idle("R12 legal pair held");
        step("R7 guest sret ignores tsr",     0, 2'b00, 0, 0, 1, 0, 1);
        idle("R10 idle after return");
        @(negedge clk);
        trap_i = 0; mret_i = 0; sret_i = 0; hret_i = 0; tsr_i = 0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule